// File: doc/BRIEF.md
# Two-Dimensional PAM16 Pair Mapper with Four-Lane Frame Dealer

This block turns constellation labels into transmit amplitudes for a four-lane PAM16 line. Each 7-bit label picks one point of a 128-point checkerboard constellation. The constellation is the set of level pairs (x, y) on the 16x16 PAM16 grid for which x + y is even. The block sends each selected point as two consecutive PAM16 symbols on one lane. The first dimension goes out first and the second dimension follows on the next cycle.

Labels arrive in beats of four, one label per lane, over a ready/valid handshake. A start-of-frame flag marks the first beat of each frame. A frame is a fixed number of two-dimensional symbols. Symbol k of a frame goes to lane k mod 4, so one beat fills all four lanes for two cycles. Every lane therefore runs at one PAM16 symbol per clock.

The output is four 5-bit signed amplitudes, an output-valid strobe and a frame-start strobe. The frame-start strobe marks the cycle in which the first symbol of a frame appears. If labels stop arriving inside a frame, the block stalls all four lanes together and raises an underrun flag. A symbol pair that has started is always finished.

Top module: `pam2d_frame_mapper`

## Requirements
- R1: Label bits [3:0] give the first-dimension level index x. Level index i is sent as the signed odd amplitude 2*i-15, in the range -15 to +15. The first dimension appears on the cycle after the beat is accepted.
- R2: The second-dimension index is y = {label[6:4], label[0]}. It is sent with the same amplitude rule on the same lane, on the cycle right after the first dimension.
- R3: On every lane, the first and second amplitudes of a pair add up to 2 modulo 4. This is the amplitude-domain form of the rule that x + y is even.
- R4: Label l of a beat sits at in_labels bits [7l+6:7l] and drives lane l. Lane l sits at out_lanes bits [5l+4:5l]. Two-dimensional symbol k of a frame therefore goes to lane k mod 4.
- R5: in_ready is low on the cycle after a beat is accepted, so at most one beat is taken every two cycles. out_valid is high on both cycles of the pair.
- R6: A frame is FRAME_SYMS/LANES accepted beats long. out_frame_start is high only together with the first dimension of the first beat of a frame.
- R7: While waiting for a frame to begin, a beat offered with in_sof low is accepted and discarded. It produces no output.
- R8: A beat with in_sof high that arrives inside a frame is treated as ordinary data. It does not restart the frame count.
- R9: If no beat is taken inside a frame after a pair ends, then on the next cycle out_valid is low, all lanes are zero and out_underrun is high. A started pair is never split.
- R10: After reset, out_valid, out_frame_start and out_underrun are low, all lanes are zero and in_ready is high.
- R11: Having no input at a frame boundary is not an underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Label beat offered |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_sof | input | 1 | Beat is the first of a frame |
| in_labels | input | LANES*7 | One 7-bit label per lane |
| out_valid | output | 1 | Lane amplitudes are valid |
| out_frame_start | output | 1 | First symbol of a frame is on the lanes |
| out_lanes | output | LANES*5 | Signed amplitude per lane |
| out_underrun | output | 1 | Mid-frame stall because of a missing beat |

## Verification
The bench builds the block with LANES=4 and FRAME_SYMS=16, so a frame is only four beats. With this size, frame wrap-around, discarding at the frame boundary, a start flag inside a frame and a mid-frame stall can all be reached within a few dozen cycles. The default frame would need 256 cycles per frame. Four lanes keep the lane dealing identical to the default, and the label table drives the extreme levels 0 and 15 as well as mixed uncoded and coded bits on every lane.

// File: rtl/pam2d_pkg.sv
package pam2d_pkg;

    localparam int LBL_W = 7;
    localparam int AMP_W = 5;

    typedef logic [LBL_W-1:0]        label_t;
    typedef logic signed [AMP_W-1:0] amp_t;

    // level index 0..15 -> odd amplitude -15..+15
    function automatic amp_t level_amp(input logic [3:0] idx);
        logic signed [5:0] wide;
        wide = $signed({1'b0, idx, 1'b0}) - 6'sd15;
        return amp_t'(wide[4:0]);
    endfunction

endpackage

// File: rtl/pam2d_level_mapper.sv
module pam2d_level_mapper
    import pam2d_pkg::*;
(
    input  label_t label,
    input  logic   second,
    output amp_t   amp
);

    logic [3:0] idx;

    always_comb begin
        if (second) begin
            idx = {label[6:4], label[0]};
        end else begin
            idx = label[3:0];
        end
        amp = level_amp(idx);
    end

endmodule

// File: rtl/pam2d_group_counter.sv
module pam2d_group_counter #(
    parameter int GROUPS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic at_start
);

    localparam int CNT_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUPS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_start = (cnt_q == '0);

endmodule

// File: rtl/pam2d_frame_mapper.sv
module pam2d_frame_mapper
    import pam2d_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int FRAME_SYMS = 512
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic                   in_sof,
    input  logic [LANES*LBL_W-1:0] in_labels,
    output logic                   out_valid,
    output logic                   out_frame_start,
    output logic [LANES*AMP_W-1:0] out_lanes,
    output logic                   out_underrun
);

    localparam int GROUPS = FRAME_SYMS / LANES;

    typedef struct packed {
        logic                              second_due;
        logic [LANES-1:0][LBL_W-1:0]       grp;
        logic                              valid;
        logic                              frame_start;
        logic                              underrun;
        logic [LANES-1:0][AMP_W-1:0]       lanes;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0][LBL_W-1:0] in_lbl;
    logic [LANES-1:0][LBL_W-1:0] sel_lbl;
    logic [LANES-1:0][AMP_W-1:0] map_amp;
    logic                        at_start;
    logic                        take;
    logic                        emit;

    assign in_lbl = in_labels;

    // one mapper per lane; it reads the held beat while the second half is due
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign sel_lbl[l] = st_q.second_due ? st_q.grp[l] : in_lbl[l];

        pam2d_level_mapper u_map (
            .label  (sel_lbl[l]),
            .second (st_q.second_due),
            .amp    (map_amp[l])
        );
    end

    pam2d_group_counter #(
        .GROUPS (GROUPS)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (take),
        .at_start (at_start)
    );

    always_comb begin
        st_d = st_q;
        // beats without a start flag are dropped while a frame is awaited
        take = in_valid && !st_q.second_due && (!at_start || in_sof);
        emit = take || st_q.second_due;

        st_d.second_due  = take;
        if (take) begin
            st_d.grp = in_lbl;
        end
        st_d.valid       = emit;
        st_d.frame_start = take && at_start;
        st_d.underrun    = !emit && !at_start;
        st_d.lanes       = emit ? map_amp : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready        = !st_q.second_due;
    assign out_valid       = st_q.valid;
    assign out_frame_start = st_q.frame_start;
    assign out_lanes       = st_q.lanes;
    assign out_underrun    = st_q.underrun;

endmodule

// File: rtl/pam2d_map_checker.sv
module pam2d_map_checker #(
    parameter int LANES      = 4,
    parameter int FRAME_SYMS = 512
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_frame_start,
    input logic               out_underrun,
    input logic [LANES*5-1:0] out_lanes
);

    localparam int FRAME_VALID = 2 * (FRAME_SYMS / LANES);
    localparam int VW          = $clog2(FRAME_VALID + 1) + 1;

    logic [VW-1:0] vcnt_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt_q <= '0;
            seen_q <= 1'b0;
        end else if (out_frame_start) begin
            vcnt_q <= VW'(1);
            seen_q <= 1'b1;
        end else if (out_valid && vcnt_q != '1) begin
            vcnt_q <= vcnt_q + 1'b1;
        end
    end

    function automatic bit all_odd(input logic [LANES*5-1:0] v);
        bit ok = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            if (!v[5*l]) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic bit pairs_ok(input logic [LANES*5-1:0] a,
                                    input logic [LANES*5-1:0] b);
        bit ok = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            int s;
            s = int'($signed(a[5*l +: 5])) + int'($signed(b[5*l +: 5]));
            if ((s & 3) != 2) ok = 1'b0;
        end
        return ok;
    endfunction

    assert_odd_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> all_odd(out_lanes));

    assert_checkerboard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> pairs_ok($past(out_lanes), out_lanes));

    assert_ready_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid ##1 in_ready);

    assert_frame_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_frame_start && seen_q) |-> (vcnt_q == VW'(FRAME_VALID)));

    assert_start_first_dim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_frame_start |-> (out_valid && !in_ready));

    assert_pair_unbroken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> out_valid);

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_lanes == '0));

    assert_underrun_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_underrun |-> !out_valid);

endmodule

bind pam2d_frame_mapper pam2d_map_checker #(
    .LANES      (LANES),
    .FRAME_SYMS (FRAME_SYMS)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_ready        (in_ready),
    .out_valid       (out_valid),
    .out_frame_start (out_frame_start),
    .out_underrun    (out_underrun),
    .out_lanes       (out_lanes)
);

// File: tb/sim_pam2d_frame_mapper.sv
`timescale 1ns/1ps
module sim_pam2d_frame_mapper;

    localparam int LANES = 4;
    localparam int FSYMS = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic              in_sof = 1'b0;
    logic [LANES*7-1:0] in_labels = '0;
    logic              out_valid;
    logic              out_frame_start;
    logic [LANES*5-1:0] out_lanes;
    logic              out_underrun;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pam2d_frame_mapper #(.LANES(LANES), .FRAME_SYMS(FSYMS)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_labels(in_labels), .out_valid(out_valid),
        .out_frame_start(out_frame_start), .out_lanes(out_lanes),
        .out_underrun(out_underrun)
    );

    // stimulus beats {lane3, lane2, lane1, lane0} and expected amplitudes per lane
    localparam logic [27:0] BEAT [4] = '{
        {7'h00, 7'h00, 7'h00, 7'h00},
        {7'h7F, 7'h7F, 7'h7F, 7'h7F},
        {7'h45, 7'h2A, 7'h10, 7'h01},
        {7'h68, 7'h5C, 7'h33, 7'h0E}
    };
    localparam int EXP_F [4][4] = '{
        '{-15, -15, -15, -15},
        '{ 15,  15,  15,  15},
        '{-13, -15,   5,  -5},
        '{ 13,  -9,   9,   1}
    };
    localparam int EXP_S [4][4] = '{
        '{-15, -15, -15, -15},
        '{ 15,  15,  15,  15},
        '{-13, -11,  -7,   3},
        '{-15,  -1,   5,   9}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lane_amp(input logic [LANES*5-1:0] v, input int l);
        return int'($signed(v[5*l +: 5]));
    endfunction

    // offers one beat at a negedge with in_ready high; returns after the pair
    task automatic beat(input int idx, input logic sof, input logic exp_fs);
        logic [LANES*5-1:0] f;
        in_labels = BEAT[idx];
        in_sof    = sof;
        in_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        f = out_lanes;
        check(out_valid == 1'b1, "R5 first half valid", int'(out_valid), 1);
        check(in_ready == 1'b0, "R5 ready gap", int'(in_ready), 0);
        check(out_frame_start == exp_fs, "R6 frame start", int'(out_frame_start), int'(exp_fs));
        for (int l = 0; l < LANES; l++) begin
            check(lane_amp(f, l) == EXP_F[idx][l], "R1 R4 first dim lane",
                  lane_amp(f, l), EXP_F[idx][l]);
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b1, "R9 pair completes", int'(out_valid), 1);
        check(out_frame_start == 1'b0, "R6 no start on second dim", int'(out_frame_start), 0);
        for (int l = 0; l < LANES; l++) begin
            check(lane_amp(out_lanes, l) == EXP_S[idx][l], "R2 R4 second dim lane",
                  lane_amp(out_lanes, l), EXP_S[idx][l]);
            check(((lane_amp(f, l) + lane_amp(out_lanes, l)) & 3) == 2, "R3 checkerboard",
                  lane_amp(f, l) + lane_amp(out_lanes, l), 2);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check(out_valid == 1'b0, "R10 valid", int'(out_valid), 0);
        check(out_lanes == '0, "R10 lanes", int'(out_lanes), 0);
        check(out_frame_start == 1'b0, "R10 frame start", int'(out_frame_start), 0);
        check(out_underrun == 1'b0, "R10 underrun", int'(out_underrun), 0);
        check(in_ready == 1'b1, "R10 ready", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // frame 1: table walk, back to back
        for (int i = 0; i < 4; i++) begin
            beat(i, (i == 0), (i == 0));
        end

        // R7 / R11: beat without start flag at the boundary is dropped
        in_labels = BEAT[1];
        in_sof    = 1'b0;
        in_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R7 dropped beat gives no output", int'(out_valid), 0);
        check(out_lanes == '0, "R7 lanes stay zero", int'(out_lanes), 0);
        check(out_underrun == 1'b0, "R11 no underrun at boundary", int'(out_underrun), 0);
        check(in_ready == 1'b1, "R7 ready after drop", int'(in_ready), 1);
        in_valid = 1'b0;

        // frame 2: start, mid-frame start flag, stall, resume
        beat(2, 1'b1, 1'b1);
        beat(3, 1'b1, 1'b0);   // R8 mid-frame flag is data
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 stall valid low", int'(out_valid), 0);
        check(out_underrun == 1'b1, "R9 underrun flagged", int'(out_underrun), 1);
        check(out_lanes == '0, "R9 lanes zero", int'(out_lanes), 0);
        beat(0, 1'b0, 1'b0);
        check(out_underrun == 1'b0, "R9 underrun clears", int'(out_underrun), 0);
        beat(1, 1'b0, 1'b0);

        // frame 3 starts after four beats, counting the flagged one (R8, R6)
        beat(3, 1'b1, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule